// File: doc/BRIEF.md
# Partial-Reconfiguration Data Intake Engine

This block is the device-side control and status logic that receives a partial-reconfiguration image from a host over a 64-bit memory-mapped register interface. The host requests an engine reset and waits for the acknowledge, picks a target region, opens a session, and then streams 32-bit configuration words into a data register. Before each push it polls a credit count, which is the number of free entries in the internal word queue. It ends the session by raising a completion bit. The queue feeds a configuration consumer through a valid/ready word port. The consumer can also report operation, CRC and image-compatibility faults.

Faults are collected in a sticky error register that the host clears by writing ones. Pushing data outside a session is recorded separately from pushing data into a full queue. In both cases the word is dropped. The header and the two interface identifier registers are read-only constants set by parameters.

The session logic is a four-state machine:
- `ST_IDLE`: no session. A control write with the start bit moves to `ST_STREAM`.
- `ST_STREAM`: data writes are accepted. A control write with the complete bit moves to `ST_DRAIN`.
- `ST_DRAIN`: waits for the queue to empty, then returns to `ST_IDLE`.
- `ST_RESET`: any state moves here while the reset-request bit is held. Clearing the bit returns to `ST_IDLE`.

Top module: `pr_intake_engine`

## Requirements
- R1: Reads at byte offset 0x00 return parameter HDR_VALUE, at 0xA8 IFID_HI_VALUE, and at 0xB0 IFID_LO_VALUE. Writes to these offsets change nothing. Reads of unmapped offsets and of the data register (0x18) return 0.
- R2: Writing 1 to control (0x08) bit 0 moves to ST_RESET on the second clock edge after the write. In ST_RESET, control bit 4 (acknowledge) reads 1, the queue is empty, the credits equal DEPTH, the controller code is 4 and the host code is 8. After bit 0 is written back to 0, the engine returns to ST_IDLE on the second edge, and the acknowledge and both codes read 0.
- R3: Control bits 9:7 hold a 3-bit region identifier that can be written and read back in every value. An engine reset does not change it.
- R4: Status (0x10) bits 8:0 report DEPTH minus the queue occupancy. An accepted data write lowers the count by one, and a consumer transfer raises it by one. When a push and a transfer fall on the same edge, the count does not change.
- R5: A control write with bit 12 set in ST_IDLE enters ST_STREAM. A control write with bit 13 set in ST_STREAM enters ST_DRAIN. ST_DRAIN returns to ST_IDLE once the queue is empty. Status bit 16 reads 1 in ST_STREAM and ST_DRAIN. Status bits 22:20 read 0 in idle, 1 in stream and 2 in drain. Control bits 12 and 13 read 1 in the session states (bit 13 in drain only) and read 0 again once the engine is idle.
- R6: Status bits 27:24 report the host-side code: 0 in idle, 1 when streaming with an empty queue, 2 when streaming with queued words, 3 in drain, and 8 in reset.
- R7: The lower 32 bits of each accepted data write leave on `cfg_data` in write order. `cfg_valid` is raised only in a session state, with a non-empty queue and no pending reset request.
- R8: A data write in ST_STREAM with zero credits sets error (0x20) bit 4, and the word is dropped.
- R9: A data write in any state other than ST_STREAM sets error bit 3, and the word is dropped.
- R10: `cfg_err` bits 0, 1 and 2 set error bits 0 (operation), 1 (CRC) and 2 (incompatible image).
- R11: Error bits stay set until 1 is written to them. If an error is set in the same cycle that its bit is cleared, the set wins. An engine reset leaves the error bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 64 | Register read data (combinational) |
| cfg_data | output | 32 | Configuration word to the consumer |
| cfg_valid | output | 1 | Configuration word available |
| cfg_ready | input | 1 | Consumer accepts the word |
| cfg_err | input | 3 | Consumer fault pulses: operation, CRC, incompatible image |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a host push and a consumer transfer. The bench raises `cfg_ready` for exactly the cycle of a data write and expects the credit count to stay where it was. It also expects the transferred word to be the oldest queued word, not the new one.

The second pair is a fault arriving and the host clearing it. A consumer CRC fault pulse is driven in the same cycle as a write-all-ones clear of the error register. The bench expects exactly the CRC bit to remain set, while every other bit is cleared.

// File: rtl/pr_intake_pkg.sv
package pr_intake_pkg;

    // Byte offsets of the register map (decoded by host software)
    localparam logic [7:0] OFF_HDR  = 8'h00;
    localparam logic [7:0] OFF_CTRL = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_DATA = 8'h18;
    localparam logic [7:0] OFF_ERR  = 8'h20;
    localparam logic [7:0] OFF_IDH  = 8'hA8;
    localparam logic [7:0] OFF_IDL  = 8'hB0;

    // Control fields
    localparam int CB_RST    = 0;
    localparam int CB_ACK    = 4;
    localparam int CB_RGN_LO = 7;
    localparam int RGN_W     = 3;
    localparam int CB_START  = 12;
    localparam int CB_DONE   = 13;

    // Status fields
    localparam int CREDIT_W   = 9;
    localparam int SB_BUSY    = 16;
    localparam int SB_CODE_LO = 20;
    localparam int SB_HOST_LO = 24;

    // Error bits
    localparam int ERR_W    = 5;
    localparam int EB_PROTO = 3;
    localparam int EB_OVF   = 4;
    localparam int FAB_W    = 3;

    // Word width towards the consumer
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_DRAIN,
        ST_RESET
    } eng_state_t;

    localparam logic [2:0] CODE_IDLE   = 3'd0;
    localparam logic [2:0] CODE_STREAM = 3'd1;
    localparam logic [2:0] CODE_DRAIN  = 3'd2;
    localparam logic [2:0] CODE_RESET  = 3'd4;

    localparam logic [3:0] HOST_IDLE  = 4'd0;
    localparam logic [3:0] HOST_WAIT  = 4'd1;
    localparam logic [3:0] HOST_PUSH  = 4'd2;
    localparam logic [3:0] HOST_DRAIN = 4'd3;
    localparam logic [3:0] HOST_RESET = 4'd8;

endpackage

// File: rtl/pr_word_queue.sv
module pr_word_queue #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pr_session_fsm.sv
module pr_session_fsm
    import pr_intake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_hold,
    input  logic       start_req,
    input  logic       done_req,
    input  logic       q_empty,
    output eng_state_t state,
    output logic [2:0] ctrl_code,
    output logic [3:0] host_code,
    output logic       busy,
    output logic       ack,
    output logic       streaming
);

    eng_state_t state_q;
    eng_state_t state_d;

    assign state = state_q;

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rst_hold)       state_d = ST_RESET;
                else if (start_req) state_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (rst_hold)      state_d = ST_RESET;
                else if (done_req) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (rst_hold)     state_d = ST_RESET;
                else if (q_empty) state_d = ST_IDLE;
            end
            ST_RESET: begin
                if (!rst_hold) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        ctrl_code = CODE_IDLE;
        host_code = HOST_IDLE;
        busy      = 1'b0;
        ack       = 1'b0;
        streaming = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctrl_code = CODE_IDLE;
                host_code = HOST_IDLE;
            end
            ST_STREAM: begin
                ctrl_code = CODE_STREAM;
                host_code = q_empty ? HOST_WAIT : HOST_PUSH;
                busy      = 1'b1;
                streaming = 1'b1;
            end
            ST_DRAIN: begin
                ctrl_code = CODE_DRAIN;
                host_code = HOST_DRAIN;
                busy      = 1'b1;
            end
            ST_RESET: begin
                ctrl_code = CODE_RESET;
                host_code = HOST_RESET;
                ack       = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pr_error_bank.sv
module pr_error_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] err_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          err_q[i] <= 1'b0;
            else if (set_vec[i]) err_q[i] <= 1'b1;
            else if (clr_vec[i]) err_q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/pr_intake_engine.sv
module pr_intake_engine
    import pr_intake_pkg::*;
#(
    parameter int          DEPTH         = 8,
    parameter logic [63:0] HDR_VALUE     = 64'h3000_0000_1000_0005,
    parameter logic [63:0] IFID_HI_VALUE = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] IFID_LO_VALUE = 64'hFEDC_BA98_7654_3210
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [63:0]       rd_data,
    output logic [WORD_W-1:0] cfg_data,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    input  logic [FAB_W-1:0]  cfg_err
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    // Register decode
    logic ctrl_wr, data_wr, err_wr;
    assign ctrl_wr = wr_en && (wr_addr == OFF_CTRL);
    assign data_wr = wr_en && (wr_addr == OFF_DATA);
    assign err_wr  = wr_en && (wr_addr == OFF_ERR);

    // Writable control fields
    logic             ctl_rst_q;
    logic [RGN_W-1:0] rgn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_rst_q <= 1'b0;
            rgn_q     <= '0;
        end else if (ctrl_wr) begin
            ctl_rst_q <= wr_data[CB_RST];
            rgn_q     <= wr_data[CB_RGN_LO +: RGN_W];
        end
    end

    // Session state machine
    eng_state_t state;
    logic [2:0] ctrl_code;
    logic [3:0] host_code;
    logic       busy, ack, streaming, q_empty;

    pr_session_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_hold  (ctl_rst_q),
        .start_req (ctrl_wr && wr_data[CB_START]),
        .done_req  (ctrl_wr && wr_data[CB_DONE]),
        .q_empty   (q_empty),
        .state     (state),
        .ctrl_code (ctrl_code),
        .host_code (host_code),
        .busy      (busy),
        .ack       (ack),
        .streaming (streaming)
    );

    // Word queue and credits
    logic [CNT_W-1:0]    q_count;
    logic [CREDIT_W-1:0] credit;
    logic                q_full, q_push, q_pop, flush;
    logic                ovf_hit, proto_hit;

    assign q_empty   = (q_count == '0);
    assign q_full    = (q_count == CNT_W'(DEPTH));
    assign credit    = CREDIT_W'(DEPTH) - CREDIT_W'(q_count);
    assign flush     = ctl_rst_q;
    assign q_push    = data_wr && streaming && !q_full;
    assign ovf_hit   = data_wr && streaming && q_full;
    assign proto_hit = data_wr && !streaming;
    assign cfg_valid = busy && !q_empty && !ctl_rst_q;
    assign q_pop     = cfg_valid && cfg_ready;

    pr_word_queue #(
        .WIDTH (WORD_W),
        .DEPTH (DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (q_push),
        .push_data (wr_data[WORD_W-1:0]),
        .pop       (q_pop),
        .pop_data  (cfg_data),
        .count     (q_count)
    );

    // Sticky error bits
    logic [ERR_W-1:0] err_set, err_clr, err_q;
    assign err_set = {ovf_hit, proto_hit, cfg_err};
    assign err_clr = err_wr ? wr_data[ERR_W-1:0] : '0;

    pr_error_bank #(.N(ERR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (err_set),
        .clr_vec (err_clr),
        .err_q   (err_q)
    );

    // Read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFF_HDR: rd_data = HDR_VALUE;
            OFF_CTRL: begin
                rd_data[CB_RST]               = ctl_rst_q;
                rd_data[CB_ACK]               = ack;
                rd_data[CB_RGN_LO +: RGN_W]   = rgn_q;
                rd_data[CB_START]             = busy;
                rd_data[CB_DONE]              = (state == ST_DRAIN);
            end
            OFF_STAT: begin
                rd_data[CREDIT_W-1:0]         = credit;
                rd_data[SB_BUSY]              = busy;
                rd_data[SB_CODE_LO +: 3]      = ctrl_code;
                rd_data[SB_HOST_LO +: 4]      = host_code;
            end
            OFF_ERR: rd_data[ERR_W-1:0] = err_q;
            OFF_IDH: rd_data = IFID_HI_VALUE;
            OFF_IDL: rd_data = IFID_LO_VALUE;
            default: rd_data = '0;
        endcase
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[63:WORD_W];

endmodule

// File: rtl/pr_intake_checker.sv
module pr_intake_checker
    import pr_intake_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          wr_addr,
    input logic [63:0]         wr_data,
    input logic [CREDIT_W-1:0] credit,
    input logic [2:0]          ctrl_code,
    input logic                ack,
    input logic                busy,
    input logic                cfg_valid,
    input logic                q_push,
    input logic                q_pop,
    input logic                flush,
    input logic                rst_hold,
    input logic [ERR_W-1:0]    err_q
);

    logic [ERR_W-1:0] clr_mask;
    logic             data_write;
    assign clr_mask   = (wr_en && wr_addr == OFF_ERR) ? wr_data[ERR_W-1:0] : '0;
    assign data_write = wr_en && (wr_addr == OFF_DATA);

    AST_CREDIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CREDIT_W'(DEPTH)); // R4

    AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && !q_pop && !flush) |=> (credit == $past(credit) - 1'b1)); // R4

    AST_ACK_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (credit == CREDIT_W'(DEPTH) && !cfg_valid)); // R2

    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_code == CODE_DRAIN && credit == CREDIT_W'(DEPTH) && !rst_hold)
        |=> (ctrl_code == CODE_IDLE)); // R5

    AST_VALID_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> busy); // R7

    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (data_write && ctrl_code == CODE_STREAM && credit == '0) |=> err_q[EB_OVF]); // R8

    AST_PROTOCOL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (data_write && ctrl_code != CODE_STREAM) |=> err_q[EB_PROTO]); // R9

    AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((err_q & $past(err_q & ~clr_mask)) == $past(err_q & ~clr_mask))); // R11

endmodule

bind pr_intake_engine pr_intake_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .credit    (credit),
    .ctrl_code (ctrl_code),
    .ack       (ack),
    .busy      (busy),
    .cfg_valid (cfg_valid),
    .q_push    (q_push),
    .q_pop     (q_pop),
    .flush     (flush),
    .rst_hold  (ctl_rst_q),
    .err_q     (err_q)
);

// File: tb/pr_intake_engine_bench.sv
module pr_intake_engine_bench;

    localparam int          DEPTH = 4;
    localparam logic [63:0] HDR   = 64'hA5A5_0001_0000_00C3;
    localparam logic [63:0] IDH   = 64'h1111_2222_3333_4444;
    localparam logic [63:0] IDL   = 64'h5555_6666_7777_8888;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic [31:0] cfg_data;
    logic        cfg_valid;
    logic        cfg_ready = 1'b0;
    logic [2:0]  cfg_err = '0;

    always #5 clk = ~clk;

    pr_intake_engine #(
        .DEPTH(DEPTH), .HDR_VALUE(HDR), .IFID_HI_VALUE(IDH), .IFID_LO_VALUE(IDL)
    ) u_pr_intake_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_data(cfg_data), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_err(cfg_err)
    );

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    logic [31:0] rx [16];
    int          rx_n = 0;
    logic [31:0] exp_w [16];
    int          exp_n = 0;

    always @(posedge clk) begin
        if (cfg_valid && cfg_ready) begin
            if (rx_n < 16) rx[rx_n] = cfg_data;
            rx_n++;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [63:0] stat(input int cr, input int busy, input int code, input int host);
        return 64'(cr) | (64'(busy) << 16) | (64'(code) << 20) | (64'(host) << 24);
    endfunction

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(8'h10, v); chk("R4 reset status", v, stat(DEPTH, 0, 0, 0));
        rd(8'h08, v); chk("R2 reset ctrl", v, 64'h0);
        rd(8'h20, v); chk("R11 reset err", v, 64'h0);

        // Constants and unmapped reads
        wr(8'h00, 64'hFFFF); wr(8'hA8, 64'h0); wr(8'hB0, 64'h1);
        rd(8'h00, v); chk("R1 header", v, HDR);
        rd(8'hA8, v); chk("R1 id high", v, IDH);
        rd(8'hB0, v); chk("R1 id low", v, IDL);
        rd(8'h40, v); chk("R1 unmapped", v, 64'h0);
        rd(8'h18, v); chk("R1 data reads zero", v, 64'h0);

        // Region sweep
        for (int r = 0; r < 8; r++) begin
            wr(8'h08, 64'(r) << 7);
            rd(8'h08, v); chk("R3 region readback", v, 64'(r) << 7);
        end

        // Data write outside session
        wr(8'h18, 64'hDEAD);
        rd(8'h20, v); chk("R9 idle push flags protocol", v, 64'h08);
        rd(8'h10, v); chk("R9 idle push dropped", v, stat(DEPTH, 0, 0, 0));
        wr(8'h20, 64'h08);
        rd(8'h20, v); chk("R11 write-one clears", v, 64'h0);

        // Session start, region 2
        wr(8'h08, (64'd2 << 7) | (64'd1 << 12));
        rd(8'h10, v); chk("R5 R6 stream empty", v, stat(DEPTH, 1, 1, 1));
        rd(8'h08, v); chk("R5 start reads set", v, (64'd2 << 7) | (64'd1 << 12));

        // Fill sweep
        for (int n = 1; n <= DEPTH; n++) begin
            exp_w[exp_n] = 32'hA000_0000 + 32'(n);
            exp_n++;
            wr(8'h18, {32'hBEEF_0000 + 32'(n), 32'hA000_0000 + 32'(n)});
            rd(8'h10, v); chk("R4 R6 credit after push", v, stat(DEPTH - n, 1, 1, 2));
        end
        wr(8'h18, 64'h0000_0000_FFFF_FFFF);
        rd(8'h20, v); chk("R8 overflow flagged", v, 64'h10);
        rd(8'h10, v); chk("R8 overflow dropped", v, stat(0, 1, 1, 2));

        // One transfer, then push and transfer on the same edge
        @(negedge clk); cfg_ready = 1'b1;
        @(negedge clk); cfg_ready = 1'b0;
        rd(8'h10, v); chk("R4 credit after transfer", v, stat(1, 1, 1, 2));
        exp_w[exp_n] = 32'hC0DE_0005; exp_n++;
        @(negedge clk);
        cfg_ready = 1'b1; wr_en = 1'b1; wr_addr = 8'h18; wr_data = 64'hC0DE_0005;
        @(negedge clk);
        cfg_ready = 1'b0; wr_en = 1'b0;
        rd(8'h10, v); chk("R4 push and transfer same edge", v, stat(1, 1, 1, 2));
        chk("R7 head word left first", 64'(rx_n), 64'd2);

        // Complete, push during drain
        wr(8'h08, (64'd2 << 7) | (64'd1 << 12) | (64'd1 << 13));
        rd(8'h10, v); chk("R5 R6 drain", v, stat(1, 1, 2, 3));
        rd(8'h08, v); chk("R5 done reads set", v, (64'd2 << 7) | (64'd3 << 12));
        wr(8'h18, 64'h77);
        rd(8'h20, v); chk("R9 drain push flags protocol", v, 64'h18);

        @(negedge clk); cfg_ready = 1'b1;
        idle(DEPTH + 4);
        cfg_ready = 1'b0;
        chk("R7 word count", 64'(rx_n), 64'(exp_n));
        for (int k = 0; k < exp_n; k++) chk("R7 word order", 64'(rx[k]), 64'(exp_w[k]));
        rd(8'h10, v); chk("R5 back to idle", v, stat(DEPTH, 0, 0, 0));
        rd(8'h08, v); chk("R5 start and done clear", v, 64'd2 << 7);
        chk("R7 no valid when idle", 64'(cfg_valid), 64'd0);

        // Fabric errors and set-versus-clear collision
        wr(8'h20, 64'h1F);
        @(negedge clk); cfg_err = 3'b101;
        @(negedge clk); cfg_err = 3'b000;
        rd(8'h20, v); chk("R10 fabric op and image", v, 64'h05);
        @(negedge clk);
        cfg_err = 3'b010; wr_en = 1'b1; wr_addr = 8'h20; wr_data = 64'h1F;
        @(negedge clk);
        cfg_err = 3'b000; wr_en = 1'b0;
        rd(8'h20, v); chk("R10 R11 set wins over clear", v, 64'h02);
        wr(8'h20, 64'h02);

        // Reset handshake mid-session
        wr(8'h18, 64'h1);
        wr(8'h08, (64'd5 << 7) | (64'd1 << 12));
        wr(8'h18, 64'h11); wr(8'h18, 64'h22);
        rd(8'h10, v); chk("R4 two queued", v, stat(DEPTH - 2, 1, 1, 2));
        wr(8'h08, (64'd5 << 7) | 64'd1);
        @(negedge clk);
        rd(8'h08, v); chk("R2 R3 ack raised", v, (64'd5 << 7) | 64'h11);
        rd(8'h10, v); chk("R2 R6 reset status", v, stat(DEPTH, 0, 4, 8));
        chk("R7 no valid in reset", 64'(cfg_valid), 64'd0);
        wr(8'h08, 64'd5 << 7);
        @(negedge clk);
        rd(8'h08, v); chk("R2 R3 released", v, 64'd5 << 7);
        rd(8'h10, v); chk("R2 idle after release", v, stat(DEPTH, 0, 0, 0));
        rd(8'h20, v); chk("R11 reset keeps errors", v, 64'h08);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule